// File: doc/BRIEF.md
# Ramp Reference Slope Generator

This block produces a 9-bit code for a reference DAC. Depending on the slope mode, the code climbs, falls, or bounces between two reference levels as a triangle. In the static mode, an external level chooses which of the two references is driven. Each step of the ramp is paced by a clock enable from an internal prescaler. The prescaler divides by 1, 2, 4 or 8, can add a fixed divide-by-4 stage, and can drop a programmable number of its enables in each window of 16, 32 or 64 cycles (pulse swallowing). Each step moves the code by 1, 2, 4 or 8.

Reference A and the swallow count are written into shadow copies. They take effect only on a transfer strobe. Reference B is taken directly. The reference mode decides the role of reference B:
- in mode 0 it is unused by the up and down ramps;
- in mode 1 it is the level driven after a halt;
- in mode 2, reaching it sends the ramp back to reference A.

Start and stop strobes act on both the slope state machine and the prescaler, each with its own programmable action. The block reports code changes on a conversion-trigger pulse, and reports start, stop, reference-switch and shadow-transfer events as one-cycle strobes.

The controller has four states:
- IDLE, the state after reset;
- RUN, in which the code is updated;
- HALT, in which the code is frozen;
- HOLD, in which reference B is driven while the ramp value is kept.

Its transitions are:
- start from IDLE enters RUN with the initial load;
- stop in RUN enters HALT, or HOLD when the stop action is freeze or the reference mode is 1;
- restart in RUN reloads the initial value;
- start from HALT or HOLD enters RUN, reloading on restart and continuing from the kept value on resume.

Top module: `ramp_ref_gen`

## Requirements
- R1: After reset, dac_code is 0, all strobes are low, the controller is in IDLE and the active reference A and swallow count are 0.
- R2: A shadow value written to shadow_ref_a or shadow_swallow has no effect until shadow_xfer is high at a clock edge. The value then becomes active at that edge, and evt_xfer_done is high for exactly the following cycle.
- R3: An initial load happens on start from IDLE and on a restart. init_mode bit0 set loads reference A, clear loads reference B. init_mode bit1 clear raises conv_trig with the load, set suppresses it.
- R4: In RUN, each prescaler enable changes the code by 1 << step_gain. slope_mode 2 adds the step and slope_mode 1 subtracts it.
- R5: The up and down ramps saturate at 511 and at 0 instead of wrapping.
- R6: With ref_mode 2, an up step that reaches or passes reference B, or a down step that reaches or falls below it, loads reference A instead.
- R7: With slope_mode 3, the code rises until it reaches reference B and is clamped there. It then falls until it reaches reference A, is clamped there, and rises again. A load of reference A starts the rise.
- R8: stop_act 1 moves RUN to HALT and freezes the code; with ref_mode 1 it moves to HOLD instead. stop_act 2 always moves RUN to HOLD. HOLD drives reference B, and evt_switch pulses on entry to HOLD and on exit from it. A stop with stop_act not 0 pulses evt_stop. A stop takes priority over a start in the same cycle.
- R9: A start with start_act 1 restarts (loads), and with start_act 2 resumes from the kept code. With start_act 0 or 3, the start is ignored and evt_start stays low. Otherwise evt_start pulses.
- R10: With slope_mode 0 in RUN, dac_code is reference B while level_sel is high and reference A while it is low. evt_switch pulses on each change of selection.
- R11: The prescaler gives one enable every (1 << psc_div) × (psc_fixdiv_off ? 1 : 4) cycles, counted from a clear.
- R12: psc_start_act and psc_stop_act each use bit0 and bit1. For psc_start_act, bit0 makes a start run the prescaler. For psc_stop_act, bit0 makes a stop halt it. In both fields, bit1 makes the trigger clear the counters. A halted prescaler gives no enables, and a halt wins over a run.
- R13: With swallow_en set, the first N prescaler enables of each window are dropped, where N is the active swallow count. The window is 16, 32 or 64 cycles for swallow_win 0, 1, 2 or 3.
- R14: conv_trig is a one-cycle pulse in the cycle after each change of dac_code. Initial loads are the exception and follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slope_mode | input | 2 | 0 static, 1 down, 2 up, 3 triangle |
| ref_mode | input | 2 | 0 A only, 1 B held after stop, 2 B restarts ramp |
| step_gain | input | 2 | Step size 1 << step_gain |
| start_act | input | 2 | Start action: 0 ignore, 1 restart, 2 resume |
| stop_act | input | 2 | Stop action: 0 ignore, 1 halt, 2 freeze on B |
| psc_start_act | input | 2 | Prescaler on start: bit0 run, bit1 clear |
| psc_stop_act | input | 2 | Prescaler on stop: bit0 halt, bit1 clear |
| init_mode | input | 2 | bit0 load A (else B), bit1 no initial trigger |
| psc_div | input | 2 | Divide by 1 << psc_div |
| psc_fixdiv_off | input | 1 | High bypasses the fixed divide-by-4 |
| swallow_en | input | 1 | Enables pulse swallowing |
| swallow_win | input | 2 | Window 16, 32, 64, 64 cycles |
| ref_b | input | 9 | Reference B |
| shadow_ref_a | input | 9 | Shadow copy of reference A |
| shadow_swallow | input | 5 | Shadow copy of the swallow count |
| shadow_xfer | input | 1 | Shadow transfer request |
| start_trig | input | 1 | Start strobe |
| stop_trig | input | 1 | Stop strobe |
| level_sel | input | 1 | Static-mode reference selector |
| dac_code | output | 9 | Code to the DAC |
| conv_trig | output | 1 | Conversion trigger pulse |
| evt_switch | output | 1 | Reference-switch strobe |
| evt_start | output | 1 | Start accepted strobe |
| evt_stop | output | 1 | Stop accepted strobe |
| evt_xfer_done | output | 1 | Shadow transfer done strobe |

## Verification
The assertions assume single-cycle start and stop strobes. They also assume that a change of slope mode never coincides with a code change they examine, which they guard against by looking at the past mode. The directed tasks keep to this: they change configuration only between strobes, pulse each trigger for one cycle, and restart the ramp after every reconfiguration. The check on enables permitting movement excludes the cycles of a start or stop, because loads and the move to HOLD change the code without a prescaler enable.

// File: rtl/slope_pkg.sv
`timescale 1ns/1ps
package slope_pkg;
    localparam int CODE_W_DEF = 9;

    localparam logic [1:0] SLP_STATIC = 2'd0;
    localparam logic [1:0] SLP_DOWN   = 2'd1;
    localparam logic [1:0] SLP_UP     = 2'd2;
    localparam logic [1:0] SLP_TRI    = 2'd3;

    localparam logic [1:0] REF_B_HOLD    = 2'd1;
    localparam logic [1:0] REF_B_RESTART = 2'd2;

    localparam logic [1:0] START_RESTART = 2'd1;
    localparam logic [1:0] START_RESUME  = 2'd2;
    localparam logic [1:0] STOP_HALT     = 2'd1;
    localparam logic [1:0] STOP_FREEZE   = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_HOLD = 2'd3
    } slope_state_e;
endpackage

// File: rtl/slope_prescaler.sv
`timescale 1ns/1ps
module slope_prescaler #(
    parameter int CNT_W = 5,
    parameter int SW_W  = 5,
    parameter int WIN_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      div_sel,
    input  logic            fix_off,
    input  logic            run_set,
    input  logic            halt,
    input  logic            clear,
    input  logic            swallow_en,
    input  logic [SW_W-1:0] swallow_n,
    input  logic [1:0]      win_sel,
    output logic            step_en
);
    logic [CNT_W-1:0] cnt_q;
    logic [WIN_W-1:0] win_q, win_lim;
    logic [SW_W-1:0]  sc_q;
    logic             run_q, tick, hit;
    logic [2:0]       shift;
    logic [CNT_W:0]   lim_ext;
    logic [CNT_W-1:0] lim;

    assign shift   = {1'b0, div_sel} + (fix_off ? 3'd0 : 3'd2);
    assign lim_ext = ({{CNT_W{1'b0}}, 1'b1} << shift) - 1'b1;
    assign lim     = lim_ext[CNT_W-1:0];

    always_comb begin
        unique case (win_sel)
            2'd0:    win_lim = WIN_W'(15);
            2'd1:    win_lim = WIN_W'(31);
            default: win_lim = WIN_W'(63);
        endcase
    end

    assign tick    = run_q && (cnt_q >= lim);
    assign hit     = tick && swallow_en && (sc_q < swallow_n);
    assign step_en = tick && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            win_q <= '0;
            sc_q  <= '0;
        end else begin
            if (halt)         run_q <= 1'b0;
            else if (run_set) run_q <= 1'b1;
            if (clear) begin
                cnt_q <= '0;
                win_q <= '0;
                sc_q  <= '0;
            end else if (run_q) begin
                cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
                win_q <= (win_q == win_lim) ? '0 : win_q + 1'b1;
                if (win_q == win_lim) sc_q <= '0;
                else if (hit)         sc_q <= sc_q + 1'b1;
            end
        end
    end

    assert_halt_blocks_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> !step_en);
endmodule

// File: rtl/slope_shadow.sv
`timescale 1ns/1ps
module slope_shadow #(
    parameter int CODE_W = 9,
    parameter int SW_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [CODE_W-1:0] sh_ref_a,
    input  logic [SW_W-1:0]   sh_swallow,
    output logic [CODE_W-1:0] ref_a,
    output logic [SW_W-1:0]   swallow_n,
    output logic              done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_a     <= '0;
            swallow_n <= '0;
            done      <= 1'b0;
        end else begin
            done <= xfer;
            if (xfer) begin
                ref_a     <= sh_ref_a;
                swallow_n <= sh_swallow;
            end
        end
    end

    assert_xfer_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer) |-> (ref_a == $past(sh_ref_a)) && (swallow_n == $past(sh_swallow)) && done);
endmodule

// File: rtl/slope_core.sv
`timescale 1ns/1ps
module slope_core
    import slope_pkg::*;
#(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        slope_mode,
    input  logic [1:0]        ref_mode,
    input  logic [1:0]        gain,
    input  logic [1:0]        start_act,
    input  logic [1:0]        stop_act,
    input  logic [1:0]        init_mode,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              level_sel,
    input  logic              step_en,
    input  logic [CODE_W-1:0] ref_a,
    input  logic [CODE_W-1:0] ref_b,
    output logic [CODE_W-1:0] dac_code,
    output logic              conv_trig,
    output logic              evt_switch,
    output logic              evt_start,
    output logic              evt_stop
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    slope_state_e state_q, state_d;
    logic [CODE_W-1:0] ramp_q, ramp_d, dac_d, step, init_val, add_sat, sub_sat, stepped;
    logic [CODE_W:0]   add_ext;
    logic dir_dn_q, dir_dn_d, dir_step, load, start_go, stop_go, selb_q, selb_d;

    assign start_go = start_trig && (start_act == START_RESTART || start_act == START_RESUME);
    assign stop_go  = stop_trig && (stop_act == STOP_HALT || stop_act == STOP_FREEZE);
    assign step     = {{(CODE_W-1){1'b0}}, 1'b1} << gain;
    assign init_val = init_mode[0] ? ref_a : ref_b;
    assign add_ext  = {1'b0, ramp_q} + {1'b0, step};
    assign add_sat  = add_ext[CODE_W] ? CODE_MAX : add_ext[CODE_W-1:0];
    assign sub_sat  = (ramp_q < step) ? '0 : ramp_q - step;

    // one ramp step for the selected slope mode
    always_comb begin
        stepped  = ramp_q;
        dir_step = dir_dn_q;
        unique case (slope_mode)
            SLP_DOWN: stepped = (ref_mode == REF_B_RESTART && sub_sat <= ref_b) ? ref_a : sub_sat;
            SLP_UP:   stepped = (ref_mode == REF_B_RESTART && add_sat >= ref_b) ? ref_a : add_sat;
            SLP_TRI: begin
                if (dir_dn_q) begin
                    if (sub_sat <= ref_a) begin stepped = ref_a; dir_step = 1'b0; end
                    else stepped = sub_sat;
                end else begin
                    if (add_sat >= ref_b) begin stepped = ref_b; dir_step = 1'b1; end
                    else stepped = add_sat;
                end
            end
            default: stepped = ramp_q;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ramp_d   = ramp_q;
        dir_dn_d = dir_dn_q;
        load     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_go) begin state_d = ST_RUN; load = 1'b1; end
            ST_RUN: begin
                if (stop_go)
                    state_d = (stop_act == STOP_FREEZE || ref_mode == REF_B_HOLD) ? ST_HOLD : ST_HALT;
                else if (start_trig && start_act == START_RESTART)
                    load = 1'b1;
                else if (step_en && slope_mode != SLP_STATIC) begin
                    ramp_d   = stepped;
                    dir_dn_d = dir_step;
                end
            end
            ST_HALT, ST_HOLD: if (start_go) begin
                state_d = ST_RUN;
                load    = (start_act == START_RESTART);
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) begin
            ramp_d   = init_val;
            dir_dn_d = ~init_mode[0];
        end
    end

    assign selb_d = (state_d == ST_HOLD) ||
                    (state_d == ST_RUN && slope_mode == SLP_STATIC && level_sel);
    assign dac_d  = selb_d ? ref_b :
                    (state_d == ST_RUN && slope_mode == SLP_STATIC) ? ref_a : ramp_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ramp_q   <= '0;
            dir_dn_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            ramp_q   <= ramp_d;
            dir_dn_q <= dir_dn_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code   <= '0;
            conv_trig  <= 1'b0;
            evt_switch <= 1'b0;
            evt_start  <= 1'b0;
            evt_stop   <= 1'b0;
            selb_q     <= 1'b0;
        end else begin
            dac_code   <= dac_d;
            conv_trig  <= load ? !init_mode[1] : (dac_d != dac_code);
            evt_switch <= (selb_d != selb_q);
            evt_start  <= start_go;
            evt_stop   <= stop_go;
            selb_q     <= selb_d;
        end
    end

    assert_hold_drives_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> dac_code == $past(ref_b));

    assert_move_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RUN && !$past(start_trig) && !$past(stop_trig) &&
         $past(slope_mode) != SLP_STATIC && dac_code != $past(dac_code)) |-> $past(step_en));

    assert_trig_on_change_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code) && !$past(start_trig)) |-> conv_trig);
endmodule

// File: rtl/ramp_ref_gen.sv
`timescale 1ns/1ps
module ramp_ref_gen
    import slope_pkg::*;
#(
    parameter int CODE_W    = CODE_W_DEF,
    parameter int SWALLOW_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           slope_mode,
    input  logic [1:0]           ref_mode,
    input  logic [1:0]           step_gain,
    input  logic [1:0]           start_act,
    input  logic [1:0]           stop_act,
    input  logic [1:0]           psc_start_act,
    input  logic [1:0]           psc_stop_act,
    input  logic [1:0]           init_mode,
    input  logic [1:0]           psc_div,
    input  logic                 psc_fixdiv_off,
    input  logic                 swallow_en,
    input  logic [1:0]           swallow_win,
    input  logic [CODE_W-1:0]    ref_b,
    input  logic [CODE_W-1:0]    shadow_ref_a,
    input  logic [SWALLOW_W-1:0] shadow_swallow,
    input  logic                 shadow_xfer,
    input  logic                 start_trig,
    input  logic                 stop_trig,
    input  logic                 level_sel,
    output logic [CODE_W-1:0]    dac_code,
    output logic                 conv_trig,
    output logic                 evt_switch,
    output logic                 evt_start,
    output logic                 evt_stop,
    output logic                 evt_xfer_done
);
    localparam int PSC_CNT_W = 5;
    localparam int WIN_W     = 6;

    logic [CODE_W-1:0]    ref_a;
    logic [SWALLOW_W-1:0] swallow_n;
    logic                 step_en, psc_run, psc_halt, psc_clear;

    assign psc_run   = start_trig && psc_start_act[0];
    assign psc_halt  = stop_trig && psc_stop_act[0];
    assign psc_clear = (start_trig && psc_start_act[1]) || (stop_trig && psc_stop_act[1]);

    slope_shadow #(.CODE_W(CODE_W), .SW_W(SWALLOW_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .xfer(shadow_xfer),
        .sh_ref_a(shadow_ref_a), .sh_swallow(shadow_swallow),
        .ref_a(ref_a), .swallow_n(swallow_n), .done(evt_xfer_done)
    );

    slope_prescaler #(.CNT_W(PSC_CNT_W), .SW_W(SWALLOW_W), .WIN_W(WIN_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .div_sel(psc_div), .fix_off(psc_fixdiv_off),
        .run_set(psc_run), .halt(psc_halt), .clear(psc_clear),
        .swallow_en(swallow_en), .swallow_n(swallow_n), .win_sel(swallow_win),
        .step_en(step_en)
    );

    slope_core #(.CODE_W(CODE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .slope_mode(slope_mode), .ref_mode(ref_mode),
        .gain(step_gain), .start_act(start_act), .stop_act(stop_act),
        .init_mode(init_mode), .start_trig(start_trig), .stop_trig(stop_trig),
        .level_sel(level_sel), .step_en(step_en), .ref_a(ref_a), .ref_b(ref_b),
        .dac_code(dac_code), .conv_trig(conv_trig), .evt_switch(evt_switch),
        .evt_start(evt_start), .evt_stop(evt_stop)
    );
endmodule

// File: tb/ramp_ref_gen_tb_top.sv
`timescale 1ns/1ps
module ramp_ref_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] slope_mode = 2'd2, ref_mode = 2'd0, step_gain = 2'd0;
    logic [1:0] start_act = 2'd1, stop_act = 2'd1, psc_start_act = 2'd3, psc_stop_act = 2'd1;
    logic [1:0] init_mode = 2'b01, psc_div = 2'd0, swallow_win = 2'd0;
    logic       psc_fixdiv_off = 1'b1, swallow_en = 1'b0;
    logic [8:0] ref_b = 9'd300, shadow_ref_a = 9'd0;
    logic [4:0] shadow_swallow = 5'd0;
    logic       shadow_xfer = 1'b0, start_trig = 1'b0, stop_trig = 1'b0, level_sel = 1'b0;
    logic [8:0] dac_code;
    logic       conv_trig, evt_switch, evt_start, evt_stop, evt_xfer_done;
    int         vectors = 0, miscompares = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    ramp_ref_gen dut_i (
        .clk(clk), .rst_n(rst_n), .slope_mode(slope_mode), .ref_mode(ref_mode),
        .step_gain(step_gain), .start_act(start_act), .stop_act(stop_act),
        .psc_start_act(psc_start_act), .psc_stop_act(psc_stop_act), .init_mode(init_mode),
        .psc_div(psc_div), .psc_fixdiv_off(psc_fixdiv_off), .swallow_en(swallow_en),
        .swallow_win(swallow_win), .ref_b(ref_b), .shadow_ref_a(shadow_ref_a),
        .shadow_swallow(shadow_swallow), .shadow_xfer(shadow_xfer), .start_trig(start_trig),
        .stop_trig(stop_trig), .level_sel(level_sel), .dac_code(dac_code),
        .conv_trig(conv_trig), .evt_switch(evt_switch), .evt_start(evt_start),
        .evt_stop(evt_stop), .evt_xfer_done(evt_xfer_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_a(input int v);
        shadow_ref_a = 9'(v);
        shadow_xfer  = 1'b1;
        tick();
        shadow_xfer  = 1'b0;
    endtask

    task automatic pulse_start();
        start_trig = 1'b1;
        tick();
        start_trig = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_trig = 1'b1;
        tick();
        stop_trig = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dac", dac_code, 0);
        chk("R1 conv", conv_trig, 0);
        chk("R1 events", {evt_switch, evt_start, evt_stop, evt_xfer_done}, 0);
    endtask

    task automatic t_shadow_init();
        shadow_ref_a = 9'd100;
        pulse_start();
        chk("R2 shadow inactive before transfer", dac_code, 0);
        chk("R3 initial trigger", conv_trig, 1);
        chk("R9 evt_start", evt_start, 1);
        load_a(100);
        chk("R2 done strobe", evt_xfer_done, 1);
        tick();
        chk("R2 done one cycle", evt_xfer_done, 0);
        pulse_start();
        chk("R3 load A after transfer", dac_code, 100);
    endtask

    task automatic t_ramp_gain();
        for (int g = 0; g < 4; g++) begin
            step_gain = 2'(g);
            pulse_start();
            chk("R4 load", dac_code, 100);
            tick();
            chk("R4 up step", dac_code, 100 + (1 << g));
            chk("R14 trig on change", conv_trig, 1);
            tick();
            chk("R4 second step", dac_code, 100 + 2 * (1 << g));
        end
        step_gain = 2'd0;
    endtask

    task automatic t_saturate();
        step_gain = 2'd3;
        load_a(505);
        pulse_start();
        tick();
        chk("R5 top saturation", dac_code, 511);
        tick();
        chk("R5 held at 511", dac_code, 511);
        chk("R14 no trig when unchanged", conv_trig, 0);
        slope_mode = 2'd1;
        step_gain  = 2'd2;
        load_a(5);
        pulse_start();
        chk("R4 down load", dac_code, 5);
        tick();
        chk("R4 down step", dac_code, 1);
        tick();
        chk("R5 bottom saturation", dac_code, 0);
        tick();
        chk("R5 held at 0", dac_code, 0);
        slope_mode = 2'd2;
        step_gain  = 2'd0;
    endtask

    task automatic t_restart_ref();
        ref_mode = 2'd2;
        step_gain = 2'd2;
        ref_b = 9'd20;
        load_a(10);
        pulse_start();
        tick(); tick();
        chk("R6 up before threshold", dac_code, 18);
        tick();
        chk("R6 up restart to A", dac_code, 10);
        slope_mode = 2'd1;
        load_a(30);
        pulse_start();
        tick(); tick();
        chk("R6 down before threshold", dac_code, 22);
        tick();
        chk("R6 down restart to A", dac_code, 30);
        ref_mode = 2'd0;
        slope_mode = 2'd2;
    endtask

    task automatic t_triangle();
        int exp_seq[7] = '{14, 18, 20, 16, 12, 10, 14};
        slope_mode = 2'd3;
        step_gain  = 2'd2;
        ref_b      = 9'd20;
        load_a(10);
        pulse_start();
        chk("R7 start at A", dac_code, 10);
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R7 triangle sequence", dac_code, exp_seq[i]);
        end
        slope_mode = 2'd2;
        step_gain  = 2'd0;
        ref_b      = 9'd300;
    endtask

    task automatic t_init_b();
        init_mode = 2'b10;
        pulse_start();
        chk("R3 load B", dac_code, 300);
        chk("R3 suppressed trigger", conv_trig, 0);
        init_mode = 2'b00;
        pulse_start();
        chk("R3 load B with trigger", conv_trig, 1);
        init_mode = 2'b01;
    endtask

    task automatic t_static();
        slope_mode = 2'd0;
        level_sel  = 1'b0;
        load_a(100);
        pulse_start();
        chk("R10 select A", dac_code, 100);
        level_sel = 1'b1;
        tick();
        chk("R10 select B", dac_code, 300);
        chk("R10 switch strobe", evt_switch, 1);
        chk("R14 trig on select", conv_trig, 1);
        tick();
        chk("R10 strobe one cycle", evt_switch, 0);
        level_sel = 1'b0;
        tick();
        chk("R10 back to A", dac_code, 100);
        slope_mode = 2'd2;
    endtask

    task automatic t_stop_start();
        load_a(50);
        pulse_start();
        tick();
        chk("R4 step", dac_code, 51);
        pulse_stop();
        chk("R8 halt freezes", dac_code, 51);
        chk("R8 evt_stop", evt_stop, 1);
        tick(); tick();
        chk("R8 stays halted", dac_code, 51);
        start_act = 2'd2;
        pulse_start();
        chk("R9 resume keeps code", dac_code, 51);
        tick();
        chk("R9 resume continues", dac_code, 52);
        stop_act = 2'd2;
        pulse_stop();
        chk("R8 freeze drives B", dac_code, 300);
        chk("R8 switch on entry", evt_switch, 1);
        tick();
        chk("R8 hold B", dac_code, 300);
        start_act = 2'd0;
        pulse_start();
        chk("R9 ignored start", dac_code, 300);
        chk("R9 ignored start no strobe", evt_start, 0);
        start_act = 2'd2;
        pulse_start();
        chk("R9 resume from hold", dac_code, 52);
        chk("R8 switch on exit", evt_switch, 1);
        tick();
        chk("R9 continues after hold", dac_code, 53);
        ref_mode = 2'd1;
        stop_act = 2'd1;
        pulse_stop();
        chk("R8 ref mode 1 holds B", dac_code, 300);
        ref_mode  = 2'd0;
        start_act = 2'd1;
    endtask

    task automatic t_psc_actions();
        pulse_start();
        tick();
        chk("R12 running", dac_code, 51);
        stop_act = 2'd0;
        pulse_stop();
        chk("R12 step at halt edge", dac_code, 52);
        chk("R8 ignored stop no strobe", evt_stop, 0);
        tick(); tick();
        chk("R12 halted prescaler", dac_code, 52);
        start_act = 2'd0;
        psc_start_act = 2'd1;
        pulse_start();
        chk("R12 run edge no step", dac_code, 52);
        tick();
        chk("R12 prescaler runs again", dac_code, 53);
        start_act = 2'd1;
        stop_act = 2'd1;
        psc_start_act = 2'd3;
    endtask

    task automatic t_prescale();
        psc_fixdiv_off = 1'b0;
        pulse_start();
        tick(); tick(); tick();
        chk("R11 div4 no step yet", dac_code, 50);
        tick();
        chk("R11 div4 step", dac_code, 51);
        psc_fixdiv_off = 1'b1;
        psc_div = 2'd1;
        pulse_start();
        tick();
        chk("R11 div2 no step yet", dac_code, 50);
        tick();
        chk("R11 div2 step", dac_code, 51);
        psc_div = 2'd0;
    endtask

    task automatic t_swallow();
        shadow_swallow = 5'd2;
        swallow_en = 1'b1;
        swallow_win = 2'd0;
        load_a(0);
        pulse_start();
        tick(); tick();
        chk("R13 first enables swallowed", dac_code, 0);
        tick();
        chk("R13 third enable passes", dac_code, 1);
        for (int i = 0; i < 13; i++) tick();
        chk("R13 fourteen steps per window", dac_code, 14);
        tick(); tick();
        chk("R13 next window swallowed", dac_code, 14);
        tick();
        chk("R13 next window passes", dac_code, 15);
        swallow_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_shadow_init();
        t_ramp_gain();
        t_saturate();
        t_restart_ref();
        t_triangle();
        t_init_b();
        t_static();
        t_stop_start();
        t_psc_actions();
        t_prescale();
        t_swallow();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule